// File: doc/BRIEF.md
# UART Diagnostic Loopback Mode Router

This block sits between one UART channel's shift engines and its two serial pins. It decides where serial data and the 1x bit-rate strobes go. A 2-bit mode field picks one of four modes. In normal mode the pins connect straight through. In auto echo, the line input is resent on the line output one bit time later, and the receiver still delivers to the host. In local loopback, the transmitter talks to its own receiver, the line output idles high and the line input is ignored. In remote loopback, the far end's data is echoed back and the local receiver is kept from delivering characters.

The 1x clocks arrive as single-cycle strobes in the system clock domain. A mode request does not take effect at once. It is applied on the next bit strobe of the clock that currently drives the line. After each switch, the line output is held at idle for one bit time, so a switch cannot produce a false start bit. The shift logic and baud generators are outside the block. The block also tells the transmitter shifter where its serial source is and which strobe clocks it.

Top module: `uart_loop_router`

## Requirements
- R1: After synchronous reset the active mode is normal (code 00): `txd_pin` follows `tx_ser`, `rx_host_en` is 1, `tx_src_echo` is 0 and no idle guard is active.
- R2: In normal mode (code 00), `txd_pin` = `tx_ser`, `rx_ser_in` = `rxd_pin`, `rx_tick_out` = `rx_bit_tick`, `tx_tick_out` = `tx_bit_tick`, `tx_src_echo` = 0 and `rx_host_en` = 1.
- R3: In auto echo mode (code 01), `txd_pin` equals the `rx_rec_bit` value captured at the most recent `rx_bit_tick`. `tx_ser` has no effect on `txd_pin`, `tx_tick_out` = `rx_bit_tick`, and `tx_src_echo` = 1.
- R4: In auto echo mode, `rx_ser_in` = `rxd_pin`, `rx_tick_out` = `rx_bit_tick` and `rx_host_en` = 1.
- R5: In local loopback mode (code 10), `rx_ser_in` = `tx_ser`, both `rx_tick_out` and `tx_tick_out` equal `tx_bit_tick`, and `tx_src_echo` = 0.
- R6: In local loopback mode, `txd_pin` is 1 whatever `tx_ser` does, and `rxd_pin` has no effect on any output.
- R7: In local loopback mode, `rx_host_en` stays 1, as in normal mode.
- R8: In remote loopback mode (code 11), `txd_pin` echoes the `rx_rec_bit` captured at the latest `rx_bit_tick`. `rx_ser_in` = `rxd_pin`, `rx_tick_out` = `tx_tick_out` = `rx_bit_tick`, `tx_src_echo` = 1, and `rx_host_en` = 0.
- R9: A `mode_sel` value that differs from the active mode is adopted at the first clock edge where the line strobe of the active mode is high. That strobe is `rx_bit_tick` for codes 01 and 11, and `tx_bit_tick` for codes 00 and 10. Until then, all outputs follow the old mode.
- R10: From the edge that adopts a new mode until the next line strobe of the new mode, `txd_pin` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Requested mode: 00 normal, 01 auto echo, 10 local loop, 11 remote loop |
| rxd_pin | input | 1 | Serial line input pin |
| tx_ser | input | 1 | Serial output of the transmitter shifter |
| rx_rec_bit | input | 1 | Bit recovered by the receiver core |
| rx_bit_tick | input | 1 | Receiver 1x bit strobe |
| tx_bit_tick | input | 1 | Transmitter 1x bit strobe |
| txd_pin | output | 1 | Serial line output pin |
| rx_ser_in | output | 1 | Serial input fed to the receiver |
| rx_tick_out | output | 1 | Bit strobe fed to the receiver |
| tx_tick_out | output | 1 | Bit strobe fed to the transmitter shifter |
| tx_src_echo | output | 1 | Transmitter source: 0 host data, 1 echo path |
| rx_host_en | output | 1 | Receiver may hand characters to the host |

## Verification
The hardest state to reach is a mode switch that lands exactly on a line strobe while another request is already waiting. The idle guard then has to restart, and it must be released by the new mode's strobe, not the old one. The stimulus makes the two bit strobes sparse and independent and changes `mode_sel` at random over thousands of cycles, so switches fall inside guard windows and in every direction between modes. A directed opening holds a request back with no strobes, to show that nothing changes early.

// File: rtl/uart_lb_pkg.sv
`timescale 1ns/1ps
package uart_lb_pkg;

    typedef enum logic [1:0] {
        LB_NORMAL = 2'b00,
        LB_ECHO   = 2'b01,
        LB_LOCAL  = 2'b10,
        LB_REMOTE = 2'b11
    } lb_mode_e;

    typedef enum logic {
        SRC_HOST = 1'b0,
        SRC_ECHO = 1'b1
    } tx_src_e;

    typedef struct packed {
        logic    txd;
        logic    rx_ser;
        logic    rx_tick;
        logic    tx_tick;
        tx_src_e tx_src;
        logic    host_en;
    } lb_route_t;

    // Modes whose line output is paced by the receiver's bit strobe
    function automatic logic runs_on_rx_clock(lb_mode_e m);
        return (m == LB_ECHO) || (m == LB_REMOTE);
    endfunction

    // Strobe that paces the line output in a given mode
    function automatic logic line_strobe(lb_mode_e m, logic rx_tk, logic tx_tk);
        return runs_on_rx_clock(m) ? rx_tk : tx_tk;
    endfunction

endpackage

// File: rtl/lb_mode_seq.sv
`timescale 1ns/1ps
module lb_mode_seq
    import uart_lb_pkg::*;
#(
    parameter int GUARD_TICKS = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic [1:0] mode_req,
    input  logic     rx_tick,
    input  logic     tx_tick,
    output lb_mode_e act_mode,
    output logic     guard_on
);
    localparam int GW = $clog2(GUARD_TICKS + 1);
    localparam logic [GW-1:0] GUARD_LOAD = GW'(GUARD_TICKS);

    lb_mode_e      req_mode;
    lb_mode_e      act_q;
    logic [GW-1:0] guard_cnt;
    logic          tick_now;

    assign req_mode = lb_mode_e'(mode_req);
    assign tick_now = line_strobe(act_q, rx_tick, tx_tick);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q     <= LB_NORMAL;
            guard_cnt <= '0;
        end else if (tick_now) begin
            if (req_mode != act_q) begin
                act_q     <= req_mode;
                guard_cnt <= GUARD_LOAD;
            end else if (guard_cnt != '0) begin
                guard_cnt <= guard_cnt - 1'b1;
            end
        end
    end

    assign act_mode = act_q;
    assign guard_on = (guard_cnt != '0);

endmodule

// File: rtl/lb_echo_line.sv
`timescale 1ns/1ps
module lb_echo_line #(
    parameter int   STAGES = 1,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic bit_in,
    output logic bit_out
);
    logic [STAGES-1:0] line_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)
                    line_q <= IDLE;
                else if (bit_tick)
                    line_q <= bit_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst)
                    line_q <= {STAGES{IDLE}};
                else if (bit_tick)
                    line_q <= {line_q[STAGES-2:0], bit_in};
            end
        end
    endgenerate

    assign bit_out = line_q[STAGES-1];

endmodule

// File: rtl/lb_route_mux.sv
`timescale 1ns/1ps
module lb_route_mux
    import uart_lb_pkg::*;
#(
    parameter logic IDLE = 1'b1
) (
    input  lb_mode_e  act_mode,
    input  logic      guard_on,
    input  logic      rxd_pin,
    input  logic      tx_ser,
    input  logic      echo_bit,
    input  logic      rx_tick,
    input  logic      tx_tick,
    output lb_route_t route
);
    lb_route_t base;

    always_comb begin
        base = '{txd: tx_ser, rx_ser: rxd_pin, rx_tick: rx_tick,
                 tx_tick: tx_tick, tx_src: SRC_HOST, host_en: 1'b1};
        unique case (act_mode)
            LB_NORMAL: ;
            LB_ECHO: begin
                base.txd     = echo_bit;
                base.tx_tick = rx_tick;
                base.tx_src  = SRC_ECHO;
            end
            LB_LOCAL: begin
                base.txd     = IDLE;
                base.rx_ser  = tx_ser;
                base.rx_tick = tx_tick;
            end
            LB_REMOTE: begin
                base.txd     = echo_bit;
                base.tx_tick = rx_tick;
                base.tx_src  = SRC_ECHO;
                base.host_en = 1'b0;
            end
            default: ;
        endcase
        route = base;
        if (guard_on)
            route.txd = IDLE;
    end

endmodule

// File: rtl/uart_loop_router.sv
`timescale 1ns/1ps
module uart_loop_router
    import uart_lb_pkg::*;
#(
    parameter int   ECHO_STAGES = 1,
    parameter int   GUARD_TICKS = 1,
    parameter logic IDLE_LEVEL  = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       rxd_pin,
    input  logic       tx_ser,
    input  logic       rx_rec_bit,
    input  logic       rx_bit_tick,
    input  logic       tx_bit_tick,
    output logic       txd_pin,
    output logic       rx_ser_in,
    output logic       rx_tick_out,
    output logic       tx_tick_out,
    output logic       tx_src_echo,
    output logic       rx_host_en
);
    lb_mode_e  act_mode;
    logic      guard_on;
    logic      echo_bit;
    lb_route_t route;

    lb_mode_seq #(.GUARD_TICKS(GUARD_TICKS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .mode_req (mode_sel),
        .rx_tick  (rx_bit_tick),
        .tx_tick  (tx_bit_tick),
        .act_mode (act_mode),
        .guard_on (guard_on)
    );

    lb_echo_line #(.STAGES(ECHO_STAGES), .IDLE(IDLE_LEVEL)) u_echo (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (rx_bit_tick),
        .bit_in   (rx_rec_bit),
        .bit_out  (echo_bit)
    );

    lb_route_mux #(.IDLE(IDLE_LEVEL)) u_mux (
        .act_mode (act_mode),
        .guard_on (guard_on),
        .rxd_pin  (rxd_pin),
        .tx_ser   (tx_ser),
        .echo_bit (echo_bit),
        .rx_tick  (rx_bit_tick),
        .tx_tick  (tx_bit_tick),
        .route    (route)
    );

    assign txd_pin     = route.txd;
    assign rx_ser_in   = route.rx_ser;
    assign rx_tick_out = route.rx_tick;
    assign tx_tick_out = route.tx_tick;
    assign tx_src_echo = (route.tx_src == SRC_ECHO);
    assign rx_host_en  = route.host_en;

endmodule

// File: rtl/lb_router_checker.sv
`timescale 1ns/1ps
module lb_router_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] act,
    input logic       guard_on,
    input logic       rx_bit_tick,
    input logic       tx_bit_tick,
    input logic       txd_pin,
    input logic       rx_tick_out,
    input logic       rx_host_en
);
    logic line_tk;
    assign line_tk = (act == 2'b01 || act == 2'b11) ? rx_bit_tick : tx_bit_tick;

    p_local_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (act == 2'b10) |-> txd_pin);

    p_local_clock_r5: assert property (@(posedge clk) disable iff (rst)
        (act == 2'b10) |-> (rx_tick_out == tx_bit_tick));

    p_remote_mute_r8: assert property (@(posedge clk) disable iff (rst)
        (act == 2'b11) |-> !rx_host_en);

    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
        !line_tk |=> (act == $past(act)));

    p_guard_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (act != $past(act)) |-> (guard_on && txd_pin));

endmodule

bind uart_loop_router lb_router_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .act         (act_mode),
    .guard_on    (guard_on),
    .rx_bit_tick (rx_bit_tick),
    .tx_bit_tick (tx_bit_tick),
    .txd_pin     (txd_pin),
    .rx_tick_out (rx_tick_out),
    .rx_host_en  (rx_host_en)
);

// File: tb/uart_loop_router_bench.sv
`timescale 1ns/1ps
module uart_loop_router_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       rxd_pin = 1'b1, tx_ser = 1'b1, rx_rec_bit = 1'b1;
    logic       rx_bit_tick = 1'b0, tx_bit_tick = 1'b0;
    logic       txd_pin, rx_ser_in, rx_tick_out, tx_tick_out, tx_src_echo, rx_host_en;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference state
    logic [1:0] m_act;
    int         m_guard;
    logic       m_echo;

    always #4 clk = ~clk;

    uart_loop_router u_uart_loop_router (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .rxd_pin(rxd_pin),
        .tx_ser(tx_ser), .rx_rec_bit(rx_rec_bit), .rx_bit_tick(rx_bit_tick),
        .tx_bit_tick(tx_bit_tick), .txd_pin(txd_pin), .rx_ser_in(rx_ser_in),
        .rx_tick_out(rx_tick_out), .tx_tick_out(tx_tick_out),
        .tx_src_echo(tx_src_echo), .rx_host_en(rx_host_en)
    );

    function automatic string tag_of(logic [1:0] mo, int kind, int grd);
        if (kind == 0 && grd > 0) return "R10";
        case (mo)
            2'b00: return "R2";
            2'b01: return (kind == 0 || kind == 3 || kind == 4) ? "R3" : "R4";
            2'b10: return (kind == 0) ? "R6" : (kind == 5) ? "R7" : "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input logic act_v, input logic exp_v, input string tag, input string what);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act_v, exp_v);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic rxd, input logic txs,
                        input logic rrec, input logic rtk, input logic ttk, input string ovr);
        logic e_txd, e_rxs, e_rtk, e_ttk, e_src, e_host, lt;
        bit   echo_m;
        @(negedge clk);
        mode_sel = m; rxd_pin = rxd; tx_ser = txs; rx_rec_bit = rrec;
        rx_bit_tick = rtk; tx_bit_tick = ttk;
        #1;
        echo_m = (m_act == 2'b01) || (m_act == 2'b11);
        e_txd  = (m_guard > 0) ? 1'b1 : (m_act == 2'b00) ? txs : (m_act == 2'b10) ? 1'b1 : m_echo;
        e_rxs  = (m_act == 2'b10) ? txs : rxd;
        e_rtk  = (m_act == 2'b10) ? ttk : rtk;
        e_ttk  = echo_m ? rtk : ttk;
        e_src  = echo_m;
        e_host = (m_act != 2'b11);
        chk(txd_pin,     e_txd,  (ovr != "") ? ovr : tag_of(m_act, 0, m_guard), "txd_pin");
        chk(rx_ser_in,   e_rxs,  (ovr != "") ? ovr : tag_of(m_act, 1, m_guard), "rx_ser_in");
        chk(rx_tick_out, e_rtk,  (ovr != "") ? ovr : tag_of(m_act, 2, m_guard), "rx_tick_out");
        chk(tx_tick_out, e_ttk,  (ovr != "") ? ovr : tag_of(m_act, 3, m_guard), "tx_tick_out");
        chk(tx_src_echo, e_src,  (ovr != "") ? ovr : tag_of(m_act, 4, m_guard), "tx_src_echo");
        chk(rx_host_en,  e_host, (ovr != "") ? ovr : tag_of(m_act, 5, m_guard), "rx_host_en");
        @(posedge clk);
        lt = echo_m ? rtk : ttk;
        if (lt) begin
            if (m != m_act) begin
                m_act   = m;
                m_guard = 1;
            end else if (m_guard > 0) begin
                m_guard--;
            end
        end
        if (rtk) m_echo = rrec;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_act = 2'b00; m_guard = 0; m_echo = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, txd follows a low tx_ser
        step(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
        step(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        // R9: local requested, no transmitter strobe yet
        step(2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
        step(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        step(2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
        // adopt local on tx strobe, then guard and loopback behaviour
        step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "");
        step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "");
        step(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "");
        step(2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "");
        // switch to echo, feed recovered bits, keep tx_ser toggling
        step(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "");
        for (int i = 0; i < 12; i++)
            step(2'b01, i[0], ~i[1], i[2] ^ i[0], (i % 2 == 0), 1'b0, "");
        // remote loopback
        step(2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "");
        for (int i = 0; i < 12; i++)
            step(2'b11, i[1], i[0], ~i[0], (i % 3 == 0), 1'b1, "");

        // constrained random: sparse strobes, occasional mode requests
        for (int i = 0; i < 6000; i++) begin
            logic [1:0] nm;
            nm = mode_sel;
            if ($urandom_range(0, 31) == 0) nm = 2'($urandom_range(0, 3));
            step(nm, 1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0), "");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule